// File: doc/BRIEF.md
# UART Transmitter with Selectable Interrupt Timing

This block is the transmit half of a UART. Software writes characters into a four-entry queue through a data port and a write strobe. A shift register takes the characters from the queue one at a time and sends each as an asynchronous frame on the serial line. The bit rate comes from an external baud-tick strobe, and each bit lasts sixteen ticks. A frame is a low start bit, eight data bits least significant first, and one or two high stop bits. The stop-bit count is set by a configuration input.

A two-bit select input sets when the one-cycle transmit interrupt fires. It can fire on every hand-off from the queue to the shifter, on a hand-off that empties the queue, or only after the last stop bit of the last queued character has left the line. The block also has two status outputs. One is a queue-full flag that tells software to stop writing. The other is a line-quiet flag, which is high only when the queue is empty and no frame is in progress. In the third interrupt mode this flag is already high when the interrupt fires, so software can rely on it to turn a driver around or to power down.

Top module: `uart_tx_irq`

## Requirements
- R1: While reset is asserted, and after it, txLine is 1, txIdle is 1, bufFull is 0 and txIrq is 0.
- R2: A frame is a start bit at 0, then wrData[0] through wrData[7], then stop bits at 1. The stop count is two when twoStop is 1 and one when it is 0. Each bit holds for 16 baudTick pulses, and txLine changes only on the clock edge that samples a baudTick pulse.
- R3: The queue holds 4 characters, and bufFull is 1 exactly when all 4 are occupied. A write while bufFull is 1 is discarded, and that character is never transmitted.
- R4: With irqSel = 2'b00, txIrq pulses on every transfer from the queue into the shift register.
- R5: With irqSel = 2'b10, txIrq pulses only on a transfer that leaves the queue empty.
- R6: With irqSel = 2'b01, txIrq pulses on the clock edge that ends the final stop bit of a frame, provided the queue is then empty. txIdle is already 1 in the cycle of that pulse.
- R7: With irqSel = 2'b11, txIrq never pulses.
- R8: txIdle is 1 exactly when the queue is empty and no frame is being sent. While txIdle is 1, txLine is 1.
- R9: If a character is waiting when the last stop bit ends, its start bit begins on that same tick, with no idle bit time in between. No irqSel = 2'b01 pulse is raised at that boundary.
- R10: txIrq is high for one clock cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrData | input | 8 | Character to queue |
| wrEn | input | 1 | Write strobe, one cycle per character |
| baudTick | input | 1 | One-cycle strobe, 16 per bit time |
| twoStop | input | 1 | 1 selects two stop bits, 0 selects one |
| irqSel | input | 2 | Interrupt timing select |
| txLine | output | 1 | Serial output, idles high |
| txIrq | output | 1 | Transmit interrupt pulse |
| bufFull | output | 1 | Queue holds 4 characters |
| txIdle | output | 1 | Queue empty and no frame in progress |

## Verification
The assertions assume three things about the inputs. baudTick is a single-cycle strobe that never stays high on two consecutive cycles. irqSel stays constant while characters are in flight. twoStop changes only while txIdle is 1. The stimulus meets all three. It drives baudTick from a fixed divide-by-four counter, and it changes irqSel and twoStop only between scenarios, after the line has gone quiet. A behavioural queue-based model predicts all four outputs on every cycle.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef struct packed {
    logic load;      // pop queue head into shifter, drive start bit
    logic sendData;  // drive next data bit and shift
    logic sendMark;  // drive high level (stop bit or idle)
  } txStrobe_t;

  typedef enum logic [1:0] {
    IRQ_ON_MOVE  = 2'b00,
    IRQ_ON_DONE  = 2'b01,
    IRQ_ON_DRAIN = 2'b10,
    IRQ_NONE     = 2'b11
  } irqMode_t;
endpackage

// File: rtl/uart_tx_dp.sv
module uart_tx_dp
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  txStrobe_t         stb,
  output logic [LVL_W-1:0]  level,
  output logic              txLine
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [DATA_W-1:0] shReg;
  logic              push;

  assign push = wrEn && (level != LVL_W'(DEPTH));

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      level  <= '0;
      shReg  <= '0;
      txLine <= 1'b1;
    end else begin
      if (push) begin
        mem[wrPtr] <= wrData;
        wrPtr      <= bump(wrPtr);
      end
      if (stb.load) rdPtr <= bump(rdPtr);
      case ({push, stb.load})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (stb.load) begin
        shReg  <= mem[rdPtr];
        txLine <= 1'b0;
      end else if (stb.sendData) begin
        txLine <= shReg[0];
        shReg  <= shReg >> 1;
      end else if (stb.sendMark) begin
        txLine <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int TICKS  = 16,
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int TICK_W = (TICKS > 1) ? $clog2(TICKS) : 1,
  localparam int BIT_W  = $clog2(DATA_W + 3)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             baudTick,
  input  logic             twoStop,
  input  logic [1:0]       irqSel,
  input  logic             wrEn,
  input  logic [LVL_W-1:0] level,
  output txStrobe_t        stb,
  output logic             txIrq,
  output logic             bufFull,
  output logic             txIdle
);
  logic              busy, busyN;
  logic [TICK_W-1:0] tickCnt, tickN;
  logic [BIT_W-1:0]  bitIdx, bitN, lastIdx;
  logic              bufEmpty, doneIdle, drained, irqN;

  assign bufEmpty = (level == '0);
  assign bufFull  = (level == LVL_W'(DEPTH));
  assign txIdle   = !busy && bufEmpty;
  assign lastIdx  = twoStop ? BIT_W'(DATA_W + 2) : BIT_W'(DATA_W + 1);
  assign drained  = (level == LVL_W'(1)) && !(wrEn && !bufFull);

  always_comb begin
    stb      = '0;
    busyN    = busy;
    tickN    = tickCnt;
    bitN     = bitIdx;
    doneIdle = 1'b0;
    if (baudTick) begin
      if (!busy) begin
        if (!bufEmpty) begin
          stb.load = 1'b1;
          busyN    = 1'b1;
          tickN    = '0;
          bitN     = '0;
        end
      end else if (tickCnt != TICK_W'(TICKS - 1)) begin
        tickN = tickCnt + 1'b1;
      end else begin
        tickN = '0;
        if (bitIdx == lastIdx) begin
          if (!bufEmpty) begin
            stb.load = 1'b1;
            bitN     = '0;
          end else begin
            busyN        = 1'b0;
            stb.sendMark = 1'b1;
            doneIdle     = !wrEn;
          end
        end else begin
          bitN = bitIdx + 1'b1;
          if (bitIdx < BIT_W'(DATA_W)) stb.sendData = 1'b1;
          else                         stb.sendMark = 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (irqMode_t'(irqSel))
      IRQ_ON_MOVE:  irqN = stb.load;
      IRQ_ON_DRAIN: irqN = stb.load && drained;
      IRQ_ON_DONE:  irqN = doneIdle;
      default:      irqN = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      tickCnt <= '0;
      bitIdx  <= '0;
      txIrq   <= 1'b0;
    end else begin
      busy    <= busyN;
      tickCnt <= tickN;
      bitIdx  <= bitN;
      txIrq   <= irqN;
    end
  end
endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int TICKS  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              baudTick,
  input  logic              twoStop,
  input  logic [1:0]        irqSel,
  output logic              txLine,
  output logic              txIrq,
  output logic              bufFull,
  output logic              txIdle
);
  txStrobe_t        stb;
  logic [LVL_W-1:0] level;

  uart_tx_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrEn(wrEn),
    .stb(stb), .level(level), .txLine(txLine)
  );

  uart_tx_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .TICKS(TICKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .twoStop(twoStop),
    .irqSel(irqSel), .wrEn(wrEn), .level(level), .stb(stb),
    .txIrq(txIrq), .bufFull(bufFull), .txIdle(txIdle)
  );
endmodule

// File: rtl/uart_tx_irq_chk.sv
module uart_tx_irq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       baudTick,
  input logic [1:0] irqSel,
  input logic       txLine,
  input logic       txIrq,
  input logic       bufFull,
  input logic       txIdle
);
  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !baudTick |=> $stable(txLine));

  // R3
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && !baudTick) |=> bufFull);

  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txIrq && $past(irqSel) == 2'b01) |-> txIdle);

  // R7
  reserved_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(irqSel) == 2'b11) |-> !txIrq);

  // R8
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    txIdle |-> txLine);

  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |=> !txIrq);
endmodule

bind uart_tx_irq uart_tx_irq_chk chk_i (
  .clk(clk), .rstN(rstN), .baudTick(baudTick), .irqSel(irqSel),
  .txLine(txLine), .txIrq(txIrq), .bufFull(bufFull), .txIdle(txIdle)
);

// File: tb/uart_tx_irq_tb_top.sv
module uart_tx_irq_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] wrData = '0;
  logic       wrEn = 1'b0;
  logic       baudTick = 1'b0;
  logic       twoStop = 1'b1;
  logic [1:0] irqSel = 2'b00;
  logic       txLine, txIrq, bufFull, txIdle;

  int checks = 0;
  int failures = 0;
  int irqCount = 0;
  int cycles = 0;
  string lineTag = "R2";
  bit   prevIrq = 1'b0;

  always #10 clk = ~clk;

  uart_tx_irq dut_i (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrEn(wrEn),
    .baudTick(baudTick), .twoStop(twoStop), .irqSel(irqSel),
    .txLine(txLine), .txIrq(txIrq), .bufFull(bufFull), .txIdle(txIdle)
  );

  // baud strobe: one cycle in four
  int divCnt = 0;
  always @(negedge clk) begin
    divCnt   <= (divCnt == 3) ? 0 : divCnt + 1;
    baudTick <= (divCnt == 3);
  end

  // behavioural reference model
  byte unsigned q[$];
  bit   bits[$];
  bit   mBusy, mLine, mIrq;
  int   mLeft;

  task automatic startFrame();
    byte unsigned d;
    d = q.pop_front();
    bits.delete();
    for (int i = 0; i < 8; i++) bits.push_back(d[i]);
    bits.push_back(1'b1);
    if (twoStop) bits.push_back(1'b1);
    mLine = 1'b0;
    mLeft = 16;
    mBusy = 1'b1;
  endtask

  always @(posedge clk) begin
    bit accept, moved, ended;
    if (!rstN) begin
      q.delete(); bits.delete();
      mBusy = 0; mLine = 1; mIrq = 0; mLeft = 0;
    end else begin
      accept = wrEn && (q.size() < 4);
      moved = 0; ended = 0;
      if (baudTick) begin
        if (!mBusy) begin
          if (q.size() > 0) begin startFrame(); moved = 1; end
        end else begin
          mLeft--;
          if (mLeft == 0) begin
            if (bits.size() > 0) begin
              mLine = bits.pop_front();
              mLeft = 16;
            end else if (q.size() > 0) begin
              startFrame(); moved = 1;
            end else begin
              mBusy = 0; mLine = 1; ended = 1;
            end
          end
        end
      end
      if (accept) q.push_back(wrData);
      case (irqSel)
        2'b00:   mIrq = moved;
        2'b10:   mIrq = moved && (q.size() == 0);
        2'b01:   mIrq = ended && (q.size() == 0);
        default: mIrq = 0;
      endcase
    end
  end

  function automatic string irqTag(input logic [1:0] s);
    case (s)
      2'b00:   return "R4";
      2'b10:   return "R5";
      2'b01:   return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check(lineTag, txLine, mLine);
      check(irqTag(irqSel), txIrq, mIrq);
      check("R3", bufFull, q.size() == 4);
      check("R8", txIdle, (!mBusy && q.size() == 0));
      if (txIrq) begin
        irqCount++;
        check("R10", prevIrq, 0);
      end
      prevIrq = txIrq;
    end
  end

  task automatic put(input byte unsigned d);
    @(negedge clk);
    wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    repeat (8) @(negedge clk);
    while (!txIdle && guard < 20000) begin @(negedge clk); guard++; end
    repeat (100) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", txLine, 1); check("R1", txIdle, 1);
    check("R1", bufFull, 0); check("R1", txIrq, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", txLine, 1); check("R1", txIdle, 1);

    // R4: single byte, two stop bits
    irqSel = 2'b00; twoStop = 1; irqCount = 0;
    put(8'hA5);
    drain();
    check("R4", irqCount, 1);

    // R5 and R3: fill queue, extra write dropped
    irqSel = 2'b10; irqCount = 0;
    @(negedge clk);
    wrEn = 1'b1;
    for (int i = 0; i < 6; i++) begin wrData = 8'h30 + 8'(i); @(negedge clk); end
    wrEn = 1'b0;
    check("R3", bufFull, 1);
    drain();
    check("R5", irqCount, 1);

    // R6: one stop bit, two bytes queued
    irqSel = 2'b01; twoStop = 0; irqCount = 0;
    put(8'h3C); put(8'hC3);
    drain();
    check("R6", irqCount, 1);

    // R7: reserved mode
    irqSel = 2'b11; twoStop = 1; irqCount = 0;
    put(8'h81); put(8'h7E);
    drain();
    check("R7", irqCount, 0);

    // R9: refill mid-frame, back-to-back, single completion pulse
    irqSel = 2'b01; irqCount = 0; lineTag = "R9";
    put(8'h55);
    repeat (300) @(negedge clk);
    put(8'hF0);
    repeat (300) @(negedge clk);
    put(8'h0F);
    drain();
    check("R9", irqCount, 1);
    lineTag = "R2";

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #3000000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule